// File: doc/BRIEF.md
# Paged Program Counter with Wrapping Return Stack

This block holds the 13-bit instruction fetch address of a small core that uses 14-bit instructions. The address is never loaded whole from outside. Instead, a separate 5-bit high-address latch supplies the upper bits whenever the low byte is written or a jump is taken. A low-byte write combines all five latch bits with the 8-bit data-bus value. A jump or call combines the top two latch bits with an 11-bit page offset taken from the instruction.

Return addresses are kept in an internal eight-entry stack. A 3-bit pointer indexes the stack and wraps freely. The stack raises no overflow or underflow indication: deep nesting overwrites the oldest entries, and an unmatched return reads whichever slot the pointer selects. A vector-load strobe saves the current address and jumps to the interrupt vector.

A parameter sets the implemented program memory size (4K or 8K words). Every address the block produces is reduced into that space.

Top module: `pc_unit`

## Requirements
- R1: While rst_ni is low, and after any reset, the fetch address and the low byte both read 0. The stack pointer returns to its start position and all stack entries read 0.
- R2: With only adv_i asserted, the fetch address becomes (previous + 1) modulo MEM_WORDS. The address 0x1FFF (8K) or 0xFFF (4K) advances to 0.
- R3: A low-byte write (pcl_we_i) loads address bits [12:8] from latch_i[4:0] and bits [7:0] from pcl_wdata_i, reduced modulo MEM_WORDS.
- R4: GOTO (goto_i) loads bits [10:0] from imm_i and bits [12:11] from latch_i[4:3], reduced modulo MEM_WORDS. latch_i[2:0] has no effect on the result.
- R5: CALL (call_i) pushes (current + 1) modulo MEM_WORDS and loads the same target that GOTO would load.
- R6: RETURN (ret_i) pops the most recently pushed entry into all 13 address bits.
- R7: The stack holds eight entries and wraps. After ten pushes, the first eight pops return pushes 10 down to 3, and the next two pops return pushes 10 and 9 again. No overflow indication exists.
- R8: A pop with no matching push returns the entry the pointer selects (0 right after reset), with no error indication.
- R9: vec_i pushes the current address unchanged and loads 0x0004.
- R10: When several strobes are asserted together, only the one with the highest priority acts. The order is vec_i, ret_i, call_i, goto_i, pcl_we_i, adv_i. With no strobe asserted, the address holds.
- R11: The fetch address is always below MEM_WORDS. With 4K words, bit 12 from the latch is dropped.
- R12: pcl_o always equals bits [7:0] of the fetch address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adv_i | input | 1 | Sequential increment |
| pcl_we_i | input | 1 | Write of the low address byte |
| pcl_wdata_i | input | 8 | Data-bus value for a low-byte write |
| goto_i | input | 1 | Jump within page |
| call_i | input | 1 | Subroutine call |
| ret_i | input | 1 | Return from subroutine |
| vec_i | input | 1 | Interrupt vector load |
| imm_i | input | 11 | Page offset from the instruction |
| latch_i | input | 5 | High-address latch |
| fetch_addr_o | output | 13 | Program memory fetch address |
| pcl_o | output | 8 | Readable low address byte |

## Verification
Two instances run the same stimulus in parallel: the default 8K configuration and a 4K one. Any difference in how latch bit 12 is masked therefore shows up directly between them.

The low-byte write is swept over every latch value and every data value. This separates errors in the latch-to-upper-bit mapping from errors in the data path. The GOTO sweep steps through the page offset under each value of the two page bits, with noise in latch bits [2:0]. This shows that only latch[4:3] reach the address.

Call sequences ten deep, followed by ten returns, tell a correctly wrapping stack apart from a saturating one or one with a misaligned pointer. Finally, all 64 combinations of strobes are applied to confirm the priority order.

// File: rtl/pc_pkg.sv
package pc_pkg;
  typedef enum logic [2:0] {
    OP_HOLD,
    OP_ADV,
    OP_PCL,
    OP_GOTO,
    OP_CALL,
    OP_RET,
    OP_VEC
  } pc_op_e;

  localparam int unsigned VEC_ADDR = 4;
endpackage

// File: rtl/pc_sel.sv
module pc_sel
  import pc_pkg::*;
(
  input  logic   adv_i,
  input  logic   pcl_we_i,
  input  logic   goto_i,
  input  logic   call_i,
  input  logic   ret_i,
  input  logic   vec_i,
  output pc_op_e op_o
);
  always_comb begin
    if (vec_i)         op_o = OP_VEC;
    else if (ret_i)    op_o = OP_RET;
    else if (call_i)   op_o = OP_CALL;
    else if (goto_i)   op_o = OP_GOTO;
    else if (pcl_we_i) op_o = OP_PCL;
    else if (adv_i)    op_o = OP_ADV;
    else               op_o = OP_HOLD;
  end
endmodule

// File: rtl/pc_next.sv
module pc_next
  import pc_pkg::*;
#(
  parameter int unsigned PC_W      = 13,
  parameter int unsigned PCL_W     = 8,
  parameter int unsigned IMM_W     = 11,
  parameter int unsigned MEM_WORDS = 8192,
  localparam int unsigned LATCH_W  = PC_W - PCL_W,
  localparam int unsigned PAGE_W   = PC_W - IMM_W
) (
  input  pc_op_e             op_i,
  input  logic [PC_W-1:0]    pc_i,
  input  logic [IMM_W-1:0]   imm_i,
  input  logic [LATCH_W-1:0] latch_i,
  input  logic [PCL_W-1:0]   wdata_i,
  input  logic [PC_W-1:0]    stack_top_i,
  output logic [PC_W-1:0]    pc_o,
  output logic [PC_W-1:0]    push_data_o
);
  localparam logic [PC_W-1:0] ADDR_MASK = PC_W'(MEM_WORDS - 1);

  logic [PC_W-1:0] inc_addr;
  logic [PC_W-1:0] page_addr;
  logic [PC_W-1:0] pcl_addr;

  assign inc_addr  = (pc_i + PC_W'(1)) & ADDR_MASK;
  assign page_addr = {latch_i[LATCH_W-1 -: PAGE_W], imm_i} & ADDR_MASK;
  assign pcl_addr  = {latch_i, wdata_i} & ADDR_MASK;

  always_comb begin
    pc_o        = pc_i;
    push_data_o = inc_addr;
    unique case (op_i)
      OP_ADV:  pc_o = inc_addr;
      OP_PCL:  pc_o = pcl_addr;
      OP_GOTO: pc_o = page_addr;
      OP_CALL: pc_o = page_addr;
      OP_RET:  pc_o = stack_top_i & ADDR_MASK;
      OP_VEC: begin
        pc_o        = PC_W'(VEC_ADDR) & ADDR_MASK;
        push_data_o = pc_i;
      end
      default: pc_o = pc_i;
    endcase
  end
endmodule

// File: rtl/pc_stack.sv
module pc_stack #(
  parameter int unsigned W     = 13,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned SP_W = $clog2(DEPTH)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] push_data_i,
  output logic [W-1:0] top_o
);
  logic [SP_W-1:0] sp_q;
  logic [SP_W-1:0] rd_ptr;
  logic [W-1:0]    mem_q [DEPTH];

  // pointer wraps by its width; DEPTH is a power of two
  assign rd_ptr = sp_q - SP_W'(1);
  assign top_o  = mem_q[rd_ptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q <= '0;
    end else if (push_i) begin
      sp_q <= sp_q + SP_W'(1);
    end else if (pop_i) begin
      sp_q <= rd_ptr;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i) begin
      mem_q[sp_q] <= push_data_i;
    end
  end
endmodule

// File: rtl/pc_unit.sv
module pc_unit
  import pc_pkg::*;
#(
  parameter int unsigned MEM_WORDS   = 8192,
  parameter int unsigned STACK_DEPTH = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        adv_i,
  input  logic        pcl_we_i,
  input  logic [7:0]  pcl_wdata_i,
  input  logic        goto_i,
  input  logic        call_i,
  input  logic        ret_i,
  input  logic        vec_i,
  input  logic [10:0] imm_i,
  input  logic [4:0]  latch_i,
  output logic [12:0] fetch_addr_o,
  output logic [7:0]  pcl_o
);
  localparam int unsigned PC_W  = 13;
  localparam int unsigned PCL_W = 8;
  localparam int unsigned IMM_W = 11;

  pc_op_e          op;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_d;
  logic [PC_W-1:0] push_data;
  logic [PC_W-1:0] stack_top;

  pc_sel u_sel (
    .adv_i    (adv_i),
    .pcl_we_i (pcl_we_i),
    .goto_i   (goto_i),
    .call_i   (call_i),
    .ret_i    (ret_i),
    .vec_i    (vec_i),
    .op_o     (op)
  );

  pc_next #(
    .PC_W      (PC_W),
    .PCL_W     (PCL_W),
    .IMM_W     (IMM_W),
    .MEM_WORDS (MEM_WORDS)
  ) u_next (
    .op_i        (op),
    .pc_i        (pc_q),
    .imm_i       (imm_i),
    .latch_i     (latch_i),
    .wdata_i     (pcl_wdata_i),
    .stack_top_i (stack_top),
    .pc_o        (pc_d),
    .push_data_o (push_data)
  );

  pc_stack #(
    .W     (PC_W),
    .DEPTH (STACK_DEPTH)
  ) u_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (op == OP_CALL || op == OP_VEC),
    .pop_i       (op == OP_RET),
    .push_data_i (push_data),
    .top_o       (stack_top)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign fetch_addr_o = pc_q;
  assign pcl_o        = pc_q[PCL_W-1:0];
endmodule

// File: rtl/pc_unit_chk.sv
module pc_unit_chk #(
  parameter int unsigned MEM_WORDS = 8192
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        adv_i,
  input logic        pcl_we_i,
  input logic [7:0]  pcl_wdata_i,
  input logic        goto_i,
  input logic        call_i,
  input logic        ret_i,
  input logic        vec_i,
  input logic [10:0] imm_i,
  input logic [4:0]  latch_i,
  input logic [12:0] fetch_addr_o
);
  localparam logic [12:0] MASK = 13'(MEM_WORDS - 1);

  logic hi_none;
  assign hi_none = !vec_i && !ret_i && !call_i;

  // R2
  a_r2_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && hi_none && !goto_i && !pcl_we_i)
    |=> fetch_addr_o == (($past(fetch_addr_o) + 13'd1) & MASK));

  // R3
  a_r3_low_byte_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pcl_we_i && hi_none && !goto_i)
    |=> fetch_addr_o == ({$past(latch_i), $past(pcl_wdata_i)} & MASK));

  // R4
  a_r4_goto_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (goto_i && hi_none)
    |=> fetch_addr_o == ({$past(latch_i[4:3]), $past(imm_i)} & MASK));

  // R5
  a_r5_call_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && !vec_i && !ret_i)
    |=> fetch_addr_o == ({$past(latch_i[4:3]), $past(imm_i)} & MASK));

  // R9
  a_r9_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_i |=> fetch_addr_o == (13'd4 & MASK));

  // R10
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !pcl_we_i && !goto_i && hi_none)
    |=> $stable(fetch_addr_o));

  // R11
  a_r11_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(fetch_addr_o) < MEM_WORDS);
endmodule

bind pc_unit pc_unit_chk #(.MEM_WORDS(MEM_WORDS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .adv_i        (adv_i),
  .pcl_we_i     (pcl_we_i),
  .pcl_wdata_i  (pcl_wdata_i),
  .goto_i       (goto_i),
  .call_i       (call_i),
  .ret_i        (ret_i),
  .vec_i        (vec_i),
  .imm_i        (imm_i),
  .latch_i      (latch_i),
  .fetch_addr_o (fetch_addr_o)
);

// File: tb/pc_unit_tb.sv
`timescale 1ns/1ps
module pc_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adv = 0, pcl_we = 0, goto_s = 0, call_s = 0, ret_s = 0, vec_s = 0;
  logic [7:0]  wdata = 0;
  logic [10:0] imm = 0;
  logic [4:0]  latch = 0;
  logic [12:0] fetch8, fetch4;
  logic [7:0]  pcl8, pcl4;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [12:0] m_pc  [2];
  logic [12:0] m_stk [2][8];
  logic [2:0]  m_sp  [2];
  logic [12:0] m_mask [2] = '{13'h1FFF, 13'h0FFF};

  always #4 clk = ~clk;

  pc_unit #(.MEM_WORDS(8192)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .adv_i(adv), .pcl_we_i(pcl_we),
    .pcl_wdata_i(wdata), .goto_i(goto_s), .call_i(call_s), .ret_i(ret_s),
    .vec_i(vec_s), .imm_i(imm), .latch_i(latch),
    .fetch_addr_o(fetch8), .pcl_o(pcl8));

  pc_unit #(.MEM_WORDS(4096)) u_dut4k (
    .clk_i(clk), .rst_ni(rst_n), .adv_i(adv), .pcl_we_i(pcl_we),
    .pcl_wdata_i(wdata), .goto_i(goto_s), .call_i(call_s), .ret_i(ret_s),
    .vec_i(vec_s), .imm_i(imm), .latch_i(latch),
    .fetch_addr_o(fetch4), .pcl_o(pcl4));

  task automatic chk(input string req, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_pc[c] = 0;
      m_sp[c] = 0;
      for (int i = 0; i < 8; i++) m_stk[c][i] = 0;
    end
  endtask

  // strobe bits: {vec, ret, call, goto, pcl, adv}
  task automatic model_step(input logic [5:0] s, input logic [10:0] im,
                            input logic [4:0] la, input logic [7:0] wd);
    for (int c = 0; c < 2; c++) begin
      if (s[5]) begin
        m_stk[c][m_sp[c]] = m_pc[c]; m_sp[c]++; m_pc[c] = 13'd4;
      end else if (s[4]) begin
        m_sp[c]--; m_pc[c] = m_stk[c][m_sp[c]];
      end else if (s[3]) begin
        m_stk[c][m_sp[c]] = (m_pc[c] + 13'd1) & m_mask[c]; m_sp[c]++;
        m_pc[c] = {la[4:3], im} & m_mask[c];
      end else if (s[2]) m_pc[c] = {la[4:3], im} & m_mask[c];
      else if (s[1])     m_pc[c] = {la, wd} & m_mask[c];
      else if (s[0])     m_pc[c] = (m_pc[c] + 13'd1) & m_mask[c];
    end
  endtask

  task automatic compare(input string req);
    chk(req, fetch8, m_pc[0]);
    chk(req, fetch4, m_pc[1]);
    chk({req, "/R12"}, {5'd0, pcl8}, {5'd0, m_pc[0][7:0]});
  endtask

  task automatic step(input logic [5:0] s, input logic [10:0] im,
                      input logic [4:0] la, input logic [7:0] wd, input string req);
    @(negedge clk);
    {vec_s, ret_s, call_s, goto_s, pcl_we, adv} = s;
    imm = im; latch = la; wdata = wd;
    @(posedge clk); #1;
    model_step(s, im, la, wd);
    compare(req);
    @(negedge clk);
    {vec_s, ret_s, call_s, goto_s, pcl_we, adv} = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    #1;
    model_reset();
    compare("R1 reset");
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_reset();
    #2;
    compare("R1 reset");
    @(negedge clk); rst_n = 1;

    // R2 increments, then R8 pop with nothing pushed
    for (int i = 0; i < 3; i++) step(6'b000001, 0, 0, 0, "R2 advance");
    step(6'b010000, 0, 0, 0, "R8 empty pop");
    // idle cycles hold: R10
    @(negedge clk); @(negedge clk); compare("R10 hold");

    // R3 full sweep of latch and data
    for (int la = 0; la < 32; la++)
      for (int wd = 0; wd < 256; wd++)
        step(6'b000010, 11'h5A5, 5'(la), 8'(wd), "R3 pcl write");

    // R4 page offset sweep, low latch bits as noise
    for (int pg = 0; pg < 4; pg++)
      for (int im = 0; im < 2048; im += 7)
        step(6'b000100, 11'(im), {2'(pg), 3'(im)}, 8'hFF, "R4 goto");
    step(6'b000100, 11'h7FF, 5'b11111, 0, "R4 goto top");

    // R2 wrap at top of each space; R11 bit 12 dropped at 4K
    step(6'b000100, 11'h7FF, 5'b11000, 0, "R11 goto top page");
    step(6'b000001, 0, 0, 0, "R2 wrap");
    step(6'b000010, 0, 5'h1F, 8'hFF, "R11 pcl mask");
    step(6'b000001, 0, 0, 0, "R2 wrap pcl");

    // R5/R6 nested calls
    do_reset();
    for (int d = 0; d < 5; d++) begin
      step(6'b001000, 11'(100 * d + 3), 5'(d << 3), 0, "R5 call");
      step(6'b000001, 0, 0, 0, "R2 advance in sub");
    end
    for (int d = 0; d < 5; d++) step(6'b010000, 0, 0, 0, "R6 return");

    // R7 ten deep, wrap
    do_reset();
    for (int d = 0; d < 10; d++)
      step(6'b001000, 11'(200 + 37 * d), 5'(d << 3), 0, "R7 push");
    for (int d = 0; d < 10; d++) step(6'b010000, 0, 0, 0, "R7 pop wrap");

    // R9 vector and return
    step(6'b000100, 11'h123, 5'b01000, 0, "R4 goto");
    step(6'b100000, 0, 0, 0, "R9 vector");
    step(6'b000001, 0, 0, 0, "R2 advance");
    step(6'b010000, 0, 0, 0, "R9 return to saved");

    // R10 all strobe combinations
    for (int s = 0; s < 64; s++)
      step(6'(s), 11'(s * 29 + 7), 5'(s * 13), 8'(s * 71), "R10 priority");

    // R1 reset clears stack and pointer
    do_reset();
    step(6'b010000, 0, 0, 0, "R1 pop after reset");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule